// File: doc/BRIEF.md
# Synchronous Buck PWM Gate Sequencer

This block turns a digitized ramp-versus-error comparison into the two gate enables of a synchronous buck power stage. A free-running counter divides the system clock into fixed switching periods (333 cycles of 100 MHz, close to 300 kHz). Each period starts with both gates off. At the start cycle the block turns the high-side gate on unless the comparator is already tripped. The high-side gate goes off when the comparator trips, or at the latest when the duty clamp is reached. After a break-before-make gap the low-side gate goes on. It stays on to near the end of the period and always for at least the minimum on time.

When a low-side interval ends normally, the block raises a one-cycle strobe. Switch-node sensing logic can use it to sample the low-side current at the last moment the low-side switch conducts. A fault-off input forces both gate outputs low in the same cycle and keeps them low until reset. The enable input parks both gates while it is low. The ramp, the error amplifier and the gate drivers sit outside this block.

Top module: `buck_gate_seq`

## Requirements
- R1: The period counter runs from 0 to PERIOD_CYC-1 (default 333) and wraps. `cycle_start_o` is high exactly while the counter is 0, including the first cycle after reset, so it pulses once every PERIOD_CYC cycles.
- R2: In an enabled period in which `cmp_trip_i` is low at count 0, `hs_gate_o` is high from count 1. It goes low after the first count c ≥ 1 at which `cmp_trip_i` is sampled high. The comparator is ignored while the high-side gate is off.
- R3: The high-side gate is never high at count 0 or beyond count MAX_ON = PERIOD_CYC*MAX_DUTY_PCT/100 (266). If the comparator never trips, it turns off after count 266.
- R4: If `cmp_trip_i` is high at count 0 of an enabled period, `hs_gate_o` stays low for the whole period. `ls_gate_o` is then high from count 1 through count PERIOD_CYC-GAP_CYC-1.
- R5: The two gates are never high together. After the high-side gate turns off at count e, the low-side gate stays low for GAP_CYC cycles and comes on at count e+GAP_CYC+1. The low-side gate goes off after count PERIOD_CYC-GAP_CYC-1, and both gates stay low through count 0 of the next period.
- R6: Every low-side interval that ends with a strobe lasted at least MIN_LS_CYC cycles (default 50).
- R7: `sense_strobe_o` is high for exactly one cycle, at count PERIOD_CYC-GAP_CYC, after each low-side interval that ends normally. It is low at all other times.
- R8: While `fault_off_i` is high, both gate outputs are low in that same cycle. From the next cycle on, both stay low and no strobe is given, even after `fault_off_i` returns low, until reset.
- R9: When `en_i` is sampled low, both gates are low from the next cycle on and no strobe is given. When `en_i` is high at count 0, the period runs normally.
- R10: Synchronous active-high reset leaves both gates low, the strobe low and the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low parks both gates |
| cmp_trip_i | input | 1 | Digitized comparator flag, high once the ramp has crossed the error voltage |
| fault_off_i | input | 1 | Forces both gates off at once and latches the off state |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| cycle_start_o | output | 1 | High in the first cycle of each switching period |
| sense_strobe_o | output | 1 | One-cycle pulse at the end of each low-side on interval |

## Verification
The hardest situations to reach from the ports are the two duty extremes. In one, the comparator has already tripped at the start cycle, so the low-side gate must come on with no high-side pulse at all. In the other, the comparator never trips, so the clamp alone ends the high-side pulse and the low-side interval shrinks to its shortest legal length. The stimulus aligns the comparator's trip point to the period count by tracking the count in the bench. It uses directed trip points of 0, 1, 2, the clamp value and its neighbours, and never. Random trip points follow, along with whole disabled periods and a fault raised in mid-pulse.

// File: rtl/buck_gate_seq_pkg.sv
package buck_gate_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HS     = 3'd1,
        ST_GAP_HL = 3'd2,
        ST_LS     = 3'd3,
        ST_GAP_LH = 3'd4,
        ST_FAULT  = 3'd5
    } gate_st_e;

endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
    parameter int PERIOD_CYC = 333,
    parameter int CW         = $clog2(PERIOD_CYC)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic [CW-1:0] cnt_o,
    output logic          start_o
);
    localparam logic [CW-1:0] LAST_C = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST_C) cnt_d = '0;
        else                 cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign cnt_o   = cnt_q;
    assign start_o = (cnt_q == '0);

    // R1: the last count is always followed by count zero
    assert_wrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q == LAST_C) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_gate_fsm.sv
module pwm_gate_fsm
    import buck_gate_seq_pkg::*;
#(
    parameter int PERIOD_CYC = 333,
    parameter int MAX_ON_CYC = 266,
    parameter int GAP_CYC    = 5,
    parameter int MIN_LS_CYC = 50,
    parameter int CW         = $clog2(PERIOD_CYC)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          en_i,
    input  logic          cmp_i,
    input  logic          fault_i,
    output logic          hs_on_o,
    output logic          ls_on_o,
    output logic          strobe_o
);
    localparam int TMAX = (GAP_CYC > MIN_LS_CYC) ? GAP_CYC : MIN_LS_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] MAX_ON_C = CW'(MAX_ON_CYC);
    localparam logic [CW-1:0] LS_END_C = CW'(PERIOD_CYC - GAP_CYC - 1);
    localparam logic [TW-1:0] GAP_LD   = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] MIN_LD   = TW'(MIN_LS_CYC - 1);

    typedef struct packed {
        gate_st_e      st;
        logic [TW-1:0] tmr;
        logic          strobe;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.strobe = 1'b0;
        if (fault_i || r_q.st == ST_FAULT) begin
            r_d.st  = ST_FAULT;
            r_d.tmr = '0;
        end else if (!en_i) begin
            r_d.st  = ST_IDLE;
            r_d.tmr = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE, ST_GAP_LH: begin
                    if (cnt_i == '0) begin
                        if (cmp_i) begin
                            r_d.st  = ST_LS;
                            r_d.tmr = MIN_LD;
                        end else begin
                            r_d.st  = ST_HS;
                        end
                    end
                end
                ST_HS: begin
                    if (cmp_i || cnt_i == MAX_ON_C) begin
                        r_d.st  = ST_GAP_HL;
                        r_d.tmr = GAP_LD;
                    end
                end
                ST_GAP_HL: begin
                    if (r_q.tmr == '0) begin
                        r_d.st  = ST_LS;
                        r_d.tmr = MIN_LD;
                    end else begin
                        r_d.tmr = r_q.tmr - TW'(1);
                    end
                end
                ST_LS: begin
                    if (r_q.tmr != '0) begin
                        r_d.tmr = r_q.tmr - TW'(1);
                    end else if (cnt_i >= LS_END_C) begin
                        r_d.st     = ST_GAP_LH;
                        r_d.strobe = 1'b1;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.st     <= ST_IDLE;
            r_q.tmr    <= '0;
            r_q.strobe <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_on_o  = (r_q.st == ST_HS);
    assign ls_on_o  = (r_q.st == ST_LS);
    assign strobe_o = r_q.strobe;

    // Length of the current or just-ended low-side interval, for R6
    logic [CW-1:0] ls_len_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)                    ls_len_q <= '0;
        else if (!ls_on_o)            ls_len_q <= '0;
        else if (ls_len_q != '1)      ls_len_q <= ls_len_q + CW'(1);
    end

    assert_hs_window_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        hs_on_o |-> (cnt_i != '0 && cnt_i <= MAX_ON_C));

    assert_zero_duty_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        ((r_q.st == ST_IDLE || r_q.st == ST_GAP_LH) && cnt_i == '0 && cmp_i
         && en_i && !fault_i) |=> (!hs_on_o && ls_on_o));

    assert_hs_after_gap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hs_on_o) |-> (!$past(ls_on_o) && !$past(ls_on_o, 2)));

    assert_ls_after_gap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ls_on_o) |-> (!$past(hs_on_o) && !$past(hs_on_o, 2)));

    assert_ls_min_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |-> (ls_len_q >= CW'(MIN_LS_CYC)));

    assert_strobe_edge_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |-> (!ls_on_o && $past(ls_on_o)));

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
    parameter int PERIOD_CYC   = 333,
    parameter int MAX_DUTY_PCT = 80,
    parameter int GAP_CYC      = 5,
    parameter int MIN_LS_CYC   = 50
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic cmp_trip_i,
    input  logic fault_off_i,
    output logic hs_gate_o,
    output logic ls_gate_o,
    output logic cycle_start_o,
    output logic sense_strobe_o
);
    localparam int CW         = $clog2(PERIOD_CYC);
    localparam int MAX_ON_CYC = PERIOD_CYC * MAX_DUTY_PCT / 100;

    logic [CW-1:0] cnt;
    logic          hs_on, ls_on, strobe;

    pwm_period_timer #(
        .PERIOD_CYC (PERIOD_CYC),
        .CW         (CW)
    ) timer_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cnt_o   (cnt),
        .start_o (cycle_start_o)
    );

    pwm_gate_fsm #(
        .PERIOD_CYC (PERIOD_CYC),
        .MAX_ON_CYC (MAX_ON_CYC),
        .GAP_CYC    (GAP_CYC),
        .MIN_LS_CYC (MIN_LS_CYC),
        .CW         (CW)
    ) fsm_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cnt_i    (cnt),
        .en_i     (en_i),
        .cmp_i    (cmp_trip_i),
        .fault_i  (fault_off_i),
        .hs_on_o  (hs_on),
        .ls_on_o  (ls_on),
        .strobe_o (strobe)
    );

    // Fault cuts both gates in the same cycle, ahead of the registered state
    assign hs_gate_o      = hs_on & ~fault_off_i;
    assign ls_gate_o      = ls_on & ~fault_off_i;
    assign sense_strobe_o = strobe;

    // R5: the two gates never overlap
    assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(hs_gate_o && ls_gate_o));

    // R8: a fault seen in the last cycle keeps both gates off and no strobe
    assert_fault_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(fault_off_i) |-> (!hs_gate_o && !ls_gate_o && !sense_strobe_o));

    // R9: a disable seen in the last cycle parks both gates
    assert_disable_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(en_i) |-> (!hs_gate_o && !ls_gate_o));

endmodule

// File: tb/buck_gate_seq_tb_top.sv
module buck_gate_seq_tb_top;
    localparam int PERIOD = 333;
    localparam int MAXON  = PERIOD * 80 / 100;
    localparam int GAP    = 5;
    localparam int MINLS  = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, cmp = 1'b0, fault = 1'b0;
    logic hs, ls, cyc, stb;

    int checks = 0;
    int fails  = 0;
    bit faulted = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    buck_gate_seq #(
        .PERIOD_CYC (PERIOD), .MAX_DUTY_PCT (80),
        .GAP_CYC (GAP), .MIN_LS_CYC (MINLS)
    ) dut_i (
        .clk_i (clk), .rst_i (rst), .en_i (en), .cmp_trip_i (cmp),
        .fault_off_i (fault), .hs_gate_o (hs), .ls_gate_o (ls),
        .cycle_start_o (cyc), .sense_strobe_o (stb)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp, input int c);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at count %0d: actual=%b expected=%b",
                     req, what, c, act, exp);
        end
    endtask

    function automatic int hs_end(input int t);
        return (t < MAXON) ? t : MAXON;
    endfunction

    function automatic bit exp_hs(input int c, input int t, input bit act);
        return act && t != 0 && c >= 1 && c <= hs_end(t);
    endfunction

    function automatic bit exp_ls(input int c, input int t, input bit act);
        int first;
        if (!act) return 1'b0;
        first = (t == 0) ? 1 : hs_end(t) + GAP + 1;
        return c >= first && c <= PERIOD - GAP - 1;
    endfunction

    // One switching period; t = first count at which the comparator is high
    task automatic run_period(input int t, input bit act, input int fault_at);
        string rq;
        for (int c = 0; c < PERIOD; c++) begin
            bit a;
            a  = act && !faulted;
            rq = faulted ? "R8" : (!act ? "R9" : (t == 0 ? "R4" :
                 (t > MAXON ? "R3" : "R2")));
            check("R1", "cycle_start", cyc, (c == 0), c);
            check(rq, "hs_gate", hs, exp_hs(c, t, a), c);
            check(rq == "R2" ? "R5" : rq, "ls_gate", ls, exp_ls(c, t, a), c);
            check("R7", "strobe", stb, a && (c == PERIOD - GAP), c);
            if (c == 0) en = act;
            cmp = (c >= t);
            if (c == fault_at) begin
                fault = 1'b1;
                #1;
                check("R8", "hs_gate same cycle", hs, 1'b0, c);
                check("R8", "ls_gate same cycle", ls, 1'b0, c);
                faulted = 1'b1;
            end
            if (fault_at >= 0 && c == fault_at + 10) fault = 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        faulted = 1'b0;
        // R10: reset state, counter at zero
        check("R10", "hs_gate", hs, 1'b0, 0);
        check("R10", "ls_gate", ls, 1'b0, 0);
        check("R10", "strobe", stb, 1'b0, 0);
        check("R10", "cycle_start", cyc, 1'b1, 0);
    endtask

    initial begin
        int directed [8];
        void'($urandom(32'd1588));
        directed = '{0, 1, 2, MAXON - 1, MAXON, MAXON + 1, PERIOD, 150};
        do_reset();
        // R2 R3 R4 R5 R6 R7: directed duty corners
        foreach (directed[i]) run_period(directed[i], 1'b1, -1);
        // random trip points
        for (int p = 0; p < 20; p++)
            run_period($urandom_range(PERIOD, 0), 1'b1, -1);
        // R9: two disabled periods, then resume
        run_period(100, 1'b0, -1);
        run_period(0, 1'b0, -1);
        run_period(120, 1'b1, -1);
        run_period(0, 1'b1, -1);
        // R8: fault in mid high-side pulse, then held off after release
        run_period(200, 1'b1, 20);
        run_period(100, 1'b1, -1);
        run_period(0, 1'b1, -1);
        // R10: reset clears the fault latch
        do_reset();
        run_period(80, 1'b1, -1);
        run_period(MAXON + 5, 1'b1, -1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule